// File: doc/BRIEF.md
# Byte-Wide I/O Port with Toggle-on-Write

This block is an 8-bit general-purpose I/O port that sits behind a simple register bus. It has three registers: a direction register, an output latch and a readback register. Each pin is driven from its latch bit, or from an override input when another peripheral, such as a timer compare unit, claims that pin. Pad inputs pass through a synchronizer. The readback value mixes latch bits for output pins with synchronized pad bits for input pins.

Writing to the readback address toggles latch bits instead of storing the value, so software can flip pins with one write. For each pin the block reports a two-bit state code. Whenever the readback value changes, it raises a one-cycle change strobe for each bit that changed, which downstream interrupt logic can use.

Top module: `gpio_toggle_port`

## Requirements
- R1: After reset the direction register, the output latch and the readback value are all zero, every pin reports state code 0 (plain input), pad_oe is zero and no change strobe is raised.
- R2: For each bit, readback (address 0) shows the latch bit when the direction bit is 1, and the synchronized pad bit when it is 0.
- R3: A write to address 0 sets the latch to the old latch XOR the written data, taking effect at the next clock edge.
- R4: The state code of pin i sits in pin_state[2i+1:2i]. When the direction bit is 1 the code is 3 (high) or 2 (low), following the value driven on the pad. When the direction bit is 0 the code is 1 (pull-up input) if the latch bit is 1, and 0 (plain input) otherwise.
- R5: A write to address 1 loads the direction register and a write to address 2 loads the latch. pad_oe equals the direction register, and pad_out equals the latch on pins that are not overridden.
- R6: While ovr_en[i] is 1, pad_out[i] equals ovr_val[i] and the latch and readback are unchanged. Clearing ovr_en[i] returns pad_out[i] to the latch bit.
- R7: When an output pin is switched to input, its readback bit shows the synchronized external pad level.
- R8: Each bit that differs between the readback values before and after a clock edge raises chg_strobe for exactly one cycle, one edge later, with chg_level holding the new readback value.
- R9: A pad input change reaches the readback value after exactly SYNC_STAGES clock edges.
- R10: A write to address 3 changes nothing, a read of address 3 returns zero, and bus_rdata is zero whenever bus_rd is low. A read with bus_rd high returns the addressed register in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 2 | Register address: 0 readback/toggle, 1 direction, 2 latch, 3 unused |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | WIDTH | Write data |
| bus_rdata | output | WIDTH | Read data, combinational |
| pad_in | input | WIDTH | External pad levels |
| pad_out | output | WIDTH | Pad output values |
| pad_oe | output | WIDTH | Pad output enables |
| ovr_en | input | WIDTH | Per-pin override enable |
| ovr_val | input | WIDTH | Per-pin override value |
| pin_state | output | 2*WIDTH | Per-pin state codes |
| chg_strobe | output | WIDTH | Per-bit readback change strobe |
| chg_level | output | WIDTH | New readback value for the strobed bits |

## Verification
The bench builds the port with its defaults: WIDTH of 8 and a two-stage synchronizer. The full byte lets one configuration hold all four state codes at once, on different pins. With two sync stages, the one-edge lag and the two-edge arrival of a pad change can both be sampled at the readback address. The toggle, override and direction-flip sequences are chained so that each one produces a distinct change-strobe pattern.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
   typedef enum logic [1:0] {
      PM_INPUT  = 2'd0,
      PM_PULLUP = 2'd1,
      PM_LOW    = 2'd2,
      PM_HIGH   = 2'd3
   } pin_mode_e;

   typedef enum logic [1:0] {
      RA_READBACK = 2'd0,
      RA_DIR      = 2'd1,
      RA_LATCH    = 2'd2,
      RA_SPARE    = 2'd3
   } reg_addr_e;
endpackage

// File: rtl/gpio_port_sync.sv
module gpio_port_sync #(
   parameter int WIDTH  = 8,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   logic [WIDTH-1:0] stage_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[0] <= '0;
            else        stage_q[0] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[s] <= '0;
            else        stage_q[s] <= stage_q[s-1];
         end
      end
   end

   assign q = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
   import gpio_port_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [1:0]       addr,
   input  logic [WIDTH-1:0] wdata,
   output logic [WIDTH-1:0] dir_q,
   output logic [WIDTH-1:0] latch_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir_q   <= '0;
         latch_q <= '0;
      end else if (wr_en) begin
         case (reg_addr_e'(addr))
            RA_READBACK: latch_q <= latch_q ^ wdata;
            RA_DIR:      dir_q   <= wdata;
            RA_LATCH:    latch_q <= wdata;
            default:     ;
         endcase
      end
   end
endmodule

// File: rtl/gpio_port_drive.sv
module gpio_port_drive
   import gpio_port_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input  logic [WIDTH-1:0]   dir,
   input  logic [WIDTH-1:0]   latch,
   input  logic [WIDTH-1:0]   ovr_en,
   input  logic [WIDTH-1:0]   ovr_val,
   output logic [WIDTH-1:0]   pad_out,
   output logic [WIDTH-1:0]   pad_oe,
   output logic [2*WIDTH-1:0] pin_state
);
   assign pad_oe = dir;

   for (genvar i = 0; i < WIDTH; i++) begin : g_pin
      pin_mode_e mode;
      logic      drive;

      assign drive = ovr_en[i] ? ovr_val[i] : latch[i];

      always_comb begin
         if (dir[i])        mode = drive ? PM_HIGH : PM_LOW;
         else if (latch[i]) mode = PM_PULLUP;
         else               mode = PM_INPUT;
      end

      assign pad_out[i]          = drive;
      assign pin_state[2*i +: 2] = mode;
   end
endmodule

// File: rtl/gpio_port_change.sv
module gpio_port_change #(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] cur,
   output logic [WIDTH-1:0] strobe,
   output logic [WIDTH-1:0] level
);
   logic [WIDTH-1:0] prev_q;
   logic [WIDTH-1:0] strobe_q;
   logic [WIDTH-1:0] level_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q   <= '0;
         strobe_q <= '0;
         level_q  <= '0;
      end else begin
         prev_q   <= cur;
         strobe_q <= cur ^ prev_q;
         level_q  <= cur;
      end
   end

   assign strobe = strobe_q;
   assign level  = level_q;
endmodule

// File: rtl/gpio_toggle_port.sv
module gpio_toggle_port
   import gpio_port_pkg::*;
#(
   parameter int WIDTH       = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [1:0]         bus_addr,
   input  logic               bus_wr,
   input  logic               bus_rd,
   input  logic [WIDTH-1:0]   bus_wdata,
   output logic [WIDTH-1:0]   bus_rdata,
   input  logic [WIDTH-1:0]   pad_in,
   output logic [WIDTH-1:0]   pad_out,
   output logic [WIDTH-1:0]   pad_oe,
   input  logic [WIDTH-1:0]   ovr_en,
   input  logic [WIDTH-1:0]   ovr_val,
   output logic [2*WIDTH-1:0] pin_state,
   output logic [WIDTH-1:0]   chg_strobe,
   output logic [WIDTH-1:0]   chg_level
);
   if (WIDTH < 1) begin : g_bad_width
      $error("gpio_toggle_port: WIDTH must be at least 1");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("gpio_toggle_port: SYNC_STAGES must be at least 2");
   end

   logic [WIDTH-1:0] dir_q;
   logic [WIDTH-1:0] latch_q;
   logic [WIDTH-1:0] pad_sync;
   logic [WIDTH-1:0] readback;

   gpio_port_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pad_in),
      .q     (pad_sync)
   );

   gpio_port_regs #(.WIDTH(WIDTH)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (bus_wr),
      .addr    (bus_addr),
      .wdata   (bus_wdata),
      .dir_q   (dir_q),
      .latch_q (latch_q)
   );

   gpio_port_drive #(.WIDTH(WIDTH)) u_drive (
      .dir       (dir_q),
      .latch     (latch_q),
      .ovr_en    (ovr_en),
      .ovr_val   (ovr_val),
      .pad_out   (pad_out),
      .pad_oe    (pad_oe),
      .pin_state (pin_state)
   );

   assign readback = (latch_q & dir_q) | (pad_sync & ~dir_q);

   gpio_port_change #(.WIDTH(WIDTH)) u_change (
      .clk    (clk),
      .rst_n  (rst_n),
      .cur    (readback),
      .strobe (chg_strobe),
      .level  (chg_level)
   );

   always_comb begin
      bus_rdata = '0;
      if (bus_rd) begin
         case (reg_addr_e'(bus_addr))
            RA_READBACK: bus_rdata = readback;
            RA_DIR:      bus_rdata = dir_q;
            RA_LATCH:    bus_rdata = latch_q;
            default:     bus_rdata = '0;
         endcase
      end
   end
endmodule

// File: rtl/gpio_toggle_port_chk.sv
module gpio_toggle_port_chk #(
   parameter int WIDTH = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic [1:0]       bus_addr,
   input logic             bus_wr,
   input logic             bus_rd,
   input logic [WIDTH-1:0] bus_wdata,
   input logic [WIDTH-1:0] bus_rdata,
   input logic [WIDTH-1:0] pad_oe,
   input logic [WIDTH-1:0] latch,
   input logic [WIDTH-1:0] readback,
   input logic [WIDTH-1:0] chg_strobe,
   input logic [WIDTH-1:0] chg_level
);
   // R3
   toggle_xor_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == 2'd0) |=> latch == ($past(latch) ^ $past(bus_wdata)));

   // R5
   dir_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == 2'd1) |=> pad_oe == $past(bus_wdata));

   // R10
   spare_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == 2'd3) |=> ($stable(latch) && $stable(pad_oe)));

   // R10
   idle_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd |-> bus_rdata == '0);

   // R8
   strobe_diff_chk: assert property (@(posedge clk) disable iff (!rst_n)
      chg_strobe == ($past(readback) ^ $past(readback, 2)));

   // R8
   strobe_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|chg_strobe) |-> chg_level == $past(readback));
endmodule

bind gpio_toggle_port gpio_toggle_port_chk #(.WIDTH(WIDTH)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .bus_addr   (bus_addr),
   .bus_wr     (bus_wr),
   .bus_rd     (bus_rd),
   .bus_wdata  (bus_wdata),
   .bus_rdata  (bus_rdata),
   .pad_oe     (pad_oe),
   .latch      (latch_q),
   .readback   (readback),
   .chg_strobe (chg_strobe),
   .chg_level  (chg_level)
);

// File: tb/gpio_toggle_port_bench.sv
`timescale 1ns/10ps
module gpio_toggle_port_bench;
   localparam int W = 8;

   localparam int SEL_RDATA  = 0;
   localparam int SEL_OUT    = 1;
   localparam int SEL_OE     = 2;
   localparam int SEL_STATE  = 3;
   localparam int SEL_STROBE = 4;
   localparam int SEL_LEVEL  = 5;

   typedef struct {
      int          sel;
      logic [15:0] exp;
      string       req;
   } item_t;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic [1:0]     bus_addr = '0;
   logic           bus_wr = 1'b0;
   logic           bus_rd = 1'b0;
   logic [W-1:0]   bus_wdata = '0;
   logic [W-1:0]   bus_rdata;
   logic [W-1:0]   pad_in = '0;
   logic [W-1:0]   pad_out;
   logic [W-1:0]   pad_oe;
   logic [W-1:0]   ovr_en = '0;
   logic [W-1:0]   ovr_val = '0;
   logic [2*W-1:0] pin_state;
   logic [W-1:0]   chg_strobe;
   logic [W-1:0]   chg_level;

   int    checks = 0;
   int    failures = 0;
   bit    done = 1'b0;
   item_t sb_q[$];
   event  sample_ev;

   always #2.5 clk = ~clk;

   gpio_toggle_port #(.WIDTH(W), .SYNC_STAGES(2)) u_gpio_toggle_port (
      .clk        (clk),
      .rst_n      (rst_n),
      .bus_addr   (bus_addr),
      .bus_wr     (bus_wr),
      .bus_rd     (bus_rd),
      .bus_wdata  (bus_wdata),
      .bus_rdata  (bus_rdata),
      .pad_in     (pad_in),
      .pad_out    (pad_out),
      .pad_oe     (pad_oe),
      .ovr_en     (ovr_en),
      .ovr_val    (ovr_val),
      .pin_state  (pin_state),
      .chg_strobe (chg_strobe),
      .chg_level  (chg_level)
   );

   // Monitor: pops expected items and compares them with the live outputs
   initial begin
      forever begin
         @(sample_ev);
         while (sb_q.size() > 0) begin
            item_t       it;
            logic [15:0] act;
            it = sb_q.pop_front();
            case (it.sel)
               SEL_RDATA:  act = {8'h00, bus_rdata};
               SEL_OUT:    act = {8'h00, pad_out};
               SEL_OE:     act = {8'h00, pad_oe};
               SEL_STATE:  act = pin_state;
               SEL_STROBE: act = {8'h00, chg_strobe};
               default:    act = {8'h00, chg_level};
            endcase
            checks++;
            if (act !== it.exp) begin
               failures++;
               $display("FAIL %s sel=%0d actual=%h expected=%h", it.req, it.sel, act, it.exp);
            end
         end
      end
   end

   // Driver side
   task automatic expect_val(int sel, logic [15:0] exp, string req);
      item_t it;
      #0.1;
      it.sel = sel; it.exp = exp; it.req = req;
      sb_q.push_back(it);
      -> sample_ev;
      #0.1;
   endtask

   task automatic read_chk(logic [1:0] a, logic [7:0] exp, string req);
      bus_addr = a;
      bus_rd   = 1'b1;
      expect_val(SEL_RDATA, {8'h00, exp}, req);
   endtask

   task automatic bus_write(logic [1:0] a, logic [7:0] d);
      @(negedge clk);
      bus_rd = 1'b0; bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic wait_neg(int n);
      for (int k = 0; k < n; k++) @(negedge clk);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      wait_neg(4);
      rst_n = 1'b1;
      // R1 reset state
      read_chk(2'd0, 8'h00, "R1");
      read_chk(2'd1, 8'h00, "R1");
      read_chk(2'd2, 8'h00, "R1");
      expect_val(SEL_STATE, 16'h0000, "R1");
      expect_val(SEL_OE, 16'h0000, "R1");
      expect_val(SEL_STROBE, 16'h0000, "R1");

      // R5 and R4: direction and latch loads
      bus_write(2'd1, 8'h0F);
      bus_write(2'd2, 8'h05);
      expect_val(SEL_OE, 16'h000F, "R5");
      expect_val(SEL_OUT, 16'h0005, "R5");
      expect_val(SEL_STATE, 16'h00BB, "R4");
      bus_write(2'd2, 8'h35);
      expect_val(SEL_STATE, 16'h05BB, "R4");

      // R2 readback composition
      pad_in = 8'hA0;
      wait_neg(3);
      read_chk(2'd0, 8'hA5, "R2");

      // R3 toggle on write
      bus_write(2'd0, 8'h03);
      read_chk(2'd2, 8'h36, "R3");
      expect_val(SEL_OUT, 16'h0036, "R3");

      // R10 spare address and idle read
      bus_write(2'd3, 8'hFF);
      read_chk(2'd1, 8'h0F, "R10");
      read_chk(2'd2, 8'h36, "R10");
      read_chk(2'd3, 8'h00, "R10");
      bus_addr = 2'd1; bus_rd = 1'b0;
      expect_val(SEL_RDATA, 16'h0000, "R10");

      // R6 override
      @(negedge clk);
      ovr_en = 8'h01; ovr_val = 8'h01;
      expect_val(SEL_OUT, 16'h0037, "R6");
      expect_val(SEL_STATE, 16'h05BF, "R6");
      read_chk(2'd0, 8'hA6, "R6");
      @(negedge clk);
      ovr_en = 8'h00;
      expect_val(SEL_OUT, 16'h0036, "R6");
      expect_val(SEL_STATE, 16'h05BE, "R4");

      // R8 change strobe after a toggle
      wait_neg(2);
      bus_write(2'd0, 8'h09);
      expect_val(SEL_STROBE, 16'h0000, "R8");
      wait_neg(1);
      expect_val(SEL_STROBE, 16'h0009, "R8");
      expect_val(SEL_LEVEL, 16'h00AF, "R8");
      wait_neg(1);
      expect_val(SEL_STROBE, 16'h0000, "R8");

      // R7 outputs turned to inputs show the pad level
      bus_write(2'd1, 8'h00);
      read_chk(2'd0, 8'hA0, "R7");
      expect_val(SEL_STATE, 16'h0555, "R4");
      wait_neg(1);
      expect_val(SEL_STROBE, 16'h000F, "R8");
      expect_val(SEL_LEVEL, 16'h00A0, "R8");

      // R9 synchronizer latency
      wait_neg(1);
      pad_in = 8'h50;
      read_chk(2'd0, 8'hA0, "R9");
      wait_neg(1);
      read_chk(2'd0, 8'hA0, "R9");
      wait_neg(1);
      read_chk(2'd0, 8'h50, "R9");
      wait_neg(1);
      expect_val(SEL_STROBE, 16'h00F0, "R8");
      expect_val(SEL_LEVEL, 16'h0050, "R8");

      wait_neg(1);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule